// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block takes a single idle-high serial line and turns each incoming character frame into a parallel byte. It oversamples the line with an external enable tick that pulses sixteen times per bit period. It confirms each start bit in the middle of the bit and collects 7 or 8 data bits, least significant first. An optional parity bit follows, then one or two stop bits. At the end of each frame it decides whether the character is delivered to the host, and it raises a flag for each fault it finds.

The host sees a holding register, a receive-full flag and three error flags: overrun, framing and parity. Each error flag stays set until the host clears it with a dedicated strobe, and reception stays halted while any of them is set. The receive-full flag is cleared by a strobe that the host issues together with its read of the holding register. Two interrupt outputs, one for data and one for errors, are gated by a single enable. Baud-rate generation and transmission are outside this block.

Top module: `serial_rx_top`

## Requirements
- R1: A frame starts when the line is low at a tick while idle. The low level is re-checked 8 ticks later, and if the line is then high the event is dropped as a glitch, so a low pulse shorter than half a bit produces no frame.
- R2: Data bits are sampled every 16 ticks from the confirmed start point. The first data bit received lands in bit 0 of the holding register.
- R3: With parity enabled, the data bits plus the parity bit must hold an even count of ones when `par_odd`=0 and an odd count when `par_odd`=1. Otherwise `par_err` is set. With parity disabled, no parity bit is expected and `par_err` is never set.
- R4: The first stop bit must be 1, or `frm_err` is set. With `stop_two`=1, the level of the second stop bit has no effect on any flag or on data, and the line is not watched for a new start until the end of the second stop bit.
- R5: If a frame completes while `rx_full` is 1, `ovr_err` is set, the holding register keeps its old value, and no parity or framing check is recorded for that frame.
- R6: On a parity or framing error (with `rx_full` at 0), the received data is still copied into the holding register.
- R7: `rx_full` becomes 1 only for a frame that passes every check. A `full_clr` pulse returns it to 0. After reset `rx_full`, all error flags, both interrupts and `rx_data` are 0.
- R8: While any error flag is 1, frames on the line are ignored: no flag and no data changes.
- R9: `irq_rx` equals `rx_full` AND `irq_en`. `irq_err` equals (any error flag) AND `irq_en`.
- R10: With `data_seven`=1 only 7 data bits are received, and bit 7 of the holding register is loaded as 0.
- R11: Each error flag is sticky and is cleared only by its own strobe: `ovr_clr`, `frm_clr` or `par_clr`. A strobe leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 1 = two stop bits, 0 = one |
| data_seven | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| irq_en | input | 1 | Enable for both interrupt outputs |
| full_clr | input | 1 | Host read strobe that clears `rx_full` |
| ovr_clr | input | 1 | Clears the overrun flag |
| frm_clr | input | 1 | Clears the framing flag |
| par_clr | input | 1 | Clears the parity flag |
| rx_data | output | 8 | Holding register |
| rx_full | output | 1 | Receive-full flag |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The embedded properties check several rules on every cycle. The sequencer stays idle while a flag is pending. A start that is high at its mid-bit check is abandoned. An overrun freezes the holding register, and a faulty frame still loads its data but never sets the full flag. The flags stay set until cleared, and a 7-bit load has a zero top bit. Other behaviours can only be shown by the bench scenarios, which compare whole frames against a reference model: the bit order, the even and odd parity rules, the second stop bit being ignored, glitch rejection at the line level, and the resumption of reception after a clear.

// File: rtl/rxp_pkg.sv
// Package: shared types for the serial receive path.
// Assumes: nothing beyond IEEE 1800-2017.
package rxp_pkg;

    // Frame sequencer states, in the order a frame walks through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Brings the asynchronous serial line into the clock domain through a chain
// of flops. Assumes STAGES >= 2 and that the line idles high, so the chain
// resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
// Module: rx_frame_fsm
// Times one frame from the oversampling tick. It confirms the start bit at
// mid-bit, shifts the data in LSB first and computes parity on the fly. It
// samples the first stop bit and, in two-stop mode, sits out the second one.
// It emits a one-cycle done pulse with the frame results.
// Assumes: the line is already synchronized and OVS is even and >= 4.
// Configuration is held stable during a frame.
module rx_frame_fsm
    import rxp_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          block,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    input  logic          cfg_seven,
    output logic          done,
    output logic [DW-1:0] frame_data,
    output logic          par_bad,
    output logic          stop_bad
);

    localparam int CW = $clog2(2 * OVS);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] MID      = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST     = CW'(OVS - 1);
    localparam logic [CW-1:0] HOLD_END = CW'(OVS + OVS / 2 - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] idx;
    logic [DW-1:0] sh_q;
    logic          pacc;
    logic          par_bad_q;
    logic          stop_bad_q;
    logic          done_q;
    logic [BW-1:0] last_idx;

    // Index of the final data bit for the selected character length.
    assign last_idx = cfg_seven ? BW'(DW - 2) : BW'(DW - 1);

    // Frame sequencer: bit timing, shifting, parity and stop sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            idx        <= '0;
            sh_q       <= '0;
            pacc       <= 1'b0;
            par_bad_q  <= 1'b0;
            stop_bad_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !rxd && !block) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxd) begin
                                state     <= ST_DATA;
                                idx       <= '0;
                                pacc      <= 1'b0;
                                par_bad_q <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            sh_q <= {rxd, sh_q[DW-1:1]};
                            pacc <= pacc ^ rxd;
                            if (idx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP;
                            else                 idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            par_bad_q <= ((pacc ^ rxd) != cfg_par_odd);
                            state     <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            stop_bad_q <= !rxd;
                            done_q     <= 1'b1;
                            state      <= cfg_two_stop ? ST_HOLD : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (cnt == HOLD_END) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Align a short character to bit 0 and zero the unused top bit.
    assign frame_data = cfg_seven ? {1'b0, sh_q[DW-1:1]} : sh_q;
    assign par_bad    = par_bad_q;
    assign stop_bad   = stop_bad_q;
    assign done       = done_q;

    AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && cnt == MID && rxd) |=> (state == ST_IDLE)); // R1
    AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && block) |=> (state == ST_IDLE)); // R8
    AST_SECOND_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> !done_q); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R7

endmodule

// File: rtl/rx_status.sv
// Module: rx_status
// Holds the received character and the full and error flags, and decides at
// each frame end whether to load, flag an overrun or flag a check failure.
// Drives both interrupt outputs.
// Assumes: done is a single-cycle pulse with stable frame results.
// When a set and a clear strobe meet in one cycle, the set wins.
module rx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] frame_data,
    input  logic          par_bad,
    input  logic          stop_bad,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    input  logic          irq_en,
    output logic [DW-1:0] hold_data,
    output logic          full,
    output logic          ovr,
    output logic          frm,
    output logic          par,
    output logic          irq_rx,
    output logic          irq_err,
    output logic          err_any
);

    logic [DW-1:0] hold_q;
    logic          full_q, ovr_q, frm_q, par_q;
    logic          accept, load, ovr_set, bad;

    assign err_any = ovr_q | frm_q | par_q;
    assign accept  = done & ~err_any;
    assign load    = accept & ~full_q;
    assign ovr_set = accept & full_q;
    assign bad     = par_bad | stop_bad;

    // Holding register: loaded on every non-overrun frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= frame_data;
    end

    // Receive-full flag: set by a clean load, cleared by the host read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              full_q <= 1'b0;
        else if (load && !bad)   full_q <= 1'b1;
        else if (clr_full)       full_q <= 1'b0;
    end

    // Sticky error flags, each with its own clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            frm_q <= 1'b0;
            par_q <= 1'b0;
        end else begin
            if (ovr_set)              ovr_q <= 1'b1;
            else if (clr_ovr)         ovr_q <= 1'b0;
            if (load && stop_bad)     frm_q <= 1'b1;
            else if (clr_frm)         frm_q <= 1'b0;
            if (load && par_bad)      par_q <= 1'b1;
            else if (clr_par)         par_q <= 1'b0;
        end
    end

    assign hold_data = hold_q;
    assign full      = full_q;
    assign ovr       = ovr_q;
    assign frm       = frm_q;
    assign par       = par_q;
    assign irq_rx    = full_q & irq_en;
    assign irq_err   = err_any & irq_en;

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> $stable(hold_q)); // R5
    AST_FAULTY_FRAME_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bad) |=> (hold_q == $past(frame_data))); // R6
    AST_FAULTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bad) |=> !full_q); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_ovr) |=> ovr_q); // R11
    AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q && !clr_frm) |=> frm_q); // R11
    AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_q && !clr_par) |=> par_q); // R11

endmodule

// File: rtl/serial_rx_top.sv
// Module: serial_rx_top
// Asynchronous serial receive path: line synchronizer, frame sequencer and
// status/holding logic.
// Assumes: os_tick pulses OVS times per bit, configuration is changed only
// between frames, and the strobes are single-cycle pulses.
module serial_rx_top #(
    parameter int OVS         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_line,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          stop_two,
    input  logic          data_seven,
    input  logic          irq_en,
    input  logic          full_clr,
    input  logic          ovr_clr,
    input  logic          frm_clr,
    input  logic          par_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          par_err,
    output logic          irq_rx,
    output logic          irq_err
);

    logic          line_s;
    logic          done;
    logic [DW-1:0] frame_data;
    logic          par_bad, stop_bad, err_any;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    rx_frame_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (os_tick),
        .rxd          (line_s),
        .block        (err_any),
        .cfg_par_en   (par_en),
        .cfg_par_odd  (par_odd),
        .cfg_two_stop (stop_two),
        .cfg_seven    (data_seven),
        .done         (done),
        .frame_data   (frame_data),
        .par_bad      (par_bad),
        .stop_bad     (stop_bad)
    );

    rx_status #(.DW(DW)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .frame_data (frame_data),
        .par_bad    (par_bad),
        .stop_bad   (stop_bad),
        .clr_full   (full_clr),
        .clr_ovr    (ovr_clr),
        .clr_frm    (frm_clr),
        .clr_par    (par_clr),
        .irq_en     (irq_en),
        .hold_data  (rx_data),
        .full       (rx_full),
        .ovr        (ovr_err),
        .frm        (frm_err),
        .par        (par_err),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err),
        .err_any    (err_any)
    );

    AST_SEVEN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && data_seven) |-> !rx_data[DW-1]); // R10

endmodule

// File: tb/sim_serial_rx_top.sv
// Bench for serial_rx_top: directed corner cases, then seeded random frames,
// all checked against a reference model kept in the bench.
module sim_serial_rx_top;

    localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0, data_seven = 1'b0, irq_en = 1'b0;
    logic       full_clr = 1'b0, ovr_clr = 1'b0, frm_clr = 1'b0, par_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, ovr_err, frm_err, par_err, irq_rx, irq_err;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    logic [7:0] m_data = 8'h00;
    logic       m_full = 1'b0, m_ovr = 1'b0, m_frm = 1'b0, m_par = 1'b0;

    serial_rx_top u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .par_en(par_en), .par_odd(par_odd), .stop_two(stop_two),
        .data_seven(data_seven), .irq_en(irq_en), .full_clr(full_clr),
        .ovr_clr(ovr_clr), .frm_clr(frm_clr), .par_clr(par_clr),
        .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
        .frm_err(frm_err), .par_err(par_err), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    always #5 clk = ~clk;

    // Oversampling tick: high on every second clock.
    always @(negedge clk) os_tick <= ~os_tick;

    function automatic logic par_bit(input logic [7:0] d, input logic seven, input logic odd);
        logic [7:0] m;
        m = seven ? (d & 8'h7F) : d;
        return (^m) ^ odd;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk("R7", {ctx, " rx_full"}, int'(rx_full), int'(m_full));
        chk("R5", {ctx, " ovr_err"}, int'(ovr_err), int'(m_ovr));
        chk("R4", {ctx, " frm_err"}, int'(frm_err), int'(m_frm));
        chk("R3", {ctx, " par_err"}, int'(par_err), int'(m_par));
        chk("R2", {ctx, " rx_data"}, int'(rx_data), int'(m_data));
        chk("R9", {ctx, " irq_rx"}, int'(irq_rx), int'(m_full & irq_en));
        chk("R9", {ctx, " irq_err"}, int'(irq_err), int'((m_ovr | m_frm | m_par) & irq_en));
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // Sends one frame and updates the model; the bad_* inputs inject faults.
    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic bad_stop, input logic stop2_low);
        int nb;
        logic [7:0] md;
        nb = data_seven ? 7 : 8;
        md = data_seven ? (d & 8'h7F) : d;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (par_en) drive_bit(par_bit(d, data_seven, par_odd) ^ bad_par);
        drive_bit(!bad_stop);
        if (stop_two) drive_bit(!stop2_low);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        if (!(m_ovr | m_frm | m_par)) begin
            if (m_full) m_ovr = 1'b1;
            else begin
                m_data = md;
                if (bad_stop) m_frm = 1'b1;
                if (par_en && bad_par) m_par = 1'b1;
                if (!bad_stop && !(par_en && bad_par)) m_full = 1'b1;
            end
        end
    endtask

    task automatic pulse_clr(input int which);
        case (which)
            0: begin full_clr = 1'b1; m_full = 1'b0; end
            1: begin ovr_clr  = 1'b1; m_ovr  = 1'b0; end
            2: begin frm_clr  = 1'b1; m_frm  = 1'b0; end
            default: begin par_clr = 1'b1; m_par = 1'b0; end
        endcase
        @(negedge clk);
        full_clr = 1'b0; ovr_clr = 1'b0; frm_clr = 1'b0; par_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("reset");                                           // R7

        // Basic 8N1 frame, bit order.
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
        check_all("8N1 A5");                                          // R2
        irq_en = 1'b1; @(negedge clk);
        check_all("irq enabled full");                                // R9
        pulse_clr(0);
        check_all("full cleared");                                    // R7

        // Glitch shorter than half a bit.
        rx_line = 1'b0; repeat (12) @(negedge clk);
        rx_line = 1'b1; repeat (400) @(negedge clk);
        chk("R1", "glitch rx_full", int'(rx_full), 0);
        check_all("after glitch");

        // Parity, odd and even, then a parity fault.
        par_en = 1'b1; par_odd = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0); check_all("odd parity ok");   // R3
        pulse_clr(0);
        par_odd = 1'b0;
        send_frame(8'h01, 1'b0, 1'b0, 1'b0); check_all("even parity ok");  // R3
        pulse_clr(0);
        send_frame(8'h77, 1'b1, 1'b0, 1'b0);
        chk("R6", "parity fault loads data", int'(rx_data), 8'h77);
        check_all("parity fault");

        // Blocked while a flag is set, then resume after clearing.
        send_frame(8'h12, 1'b0, 1'b0, 1'b0);
        chk("R8", "blocked data", int'(rx_data), 8'h77);
        check_all("blocked");
        pulse_clr(3);
        check_all("par cleared");                                     // R11
        send_frame(8'h12, 1'b0, 1'b0, 1'b0);
        check_all("resumed");                                         // R8

        // Overrun: full not cleared.
        send_frame(8'hEE, 1'b0, 1'b0, 1'b0);
        chk("R5", "overrun keeps data", int'(rx_data), 8'h12);
        check_all("overrun");
        pulse_clr(1); pulse_clr(0);
        check_all("ovr and full cleared");                            // R11

        // Framing with two stop bits.
        par_en = 1'b0; stop_two = 1'b1;
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R4", "second stop low ignored", int'(frm_err), 0);
        check_all("stop2 low");
        pulse_clr(0);
        send_frame(8'hC3, 1'b0, 1'b1, 1'b0);
        chk("R4", "first stop low", int'(frm_err), 1);
        check_all("stop1 low");
        pulse_clr(2);
        check_all("frm cleared");                                     // R11

        // Seven-bit character: top bit zero.
        stop_two = 1'b0; data_seven = 1'b1;
        send_frame(8'hFF, 1'b0, 1'b0, 1'b0);
        chk("R10", "seven-bit msb", int'(rx_data), 8'h7F);
        check_all("seven bit");
        data_seven = 1'b0;

        // Seeded random frames.
        for (int n = 0; n < 110; n++) begin
            par_en     = 1'($urandom);
            par_odd    = 1'($urandom);
            stop_two   = 1'($urandom);
            data_seven = 1'($urandom);
            irq_en     = 1'($urandom);
            @(negedge clk);
            if ($urandom % 3 != 0 && m_full) pulse_clr(0);
            if ($urandom % 2 == 0 && m_ovr)   pulse_clr(1);
            if ($urandom % 2 == 0 && m_frm)   pulse_clr(2);
            if ($urandom % 2 == 0 && m_par)   pulse_clr(3);
            send_frame(8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
                       1'($urandom));
            check_all("random");
        end

        finish_run();
    end

endmodule